// File: doc/BRIEF.md
# Transmit Queue Interrupt Controller

This block sits between a CPU register bus and the shift register of a serial transmitter. It holds the transmitter's 16-bit control word and a byte queue that software fills through a push port. It also keeps a "queue running low" flag. The flag rises when the shift register takes a byte and leaves the queue at or under a programmable low-water mark. An interrupt request goes out whenever the flag is set and software has enabled the transmit interrupt.

Software acknowledges the flag with a guarded handshake. It first reads the flag as 1, then writes 0 to it. The write takes effect only if the queue now holds more bytes than the low-water mark. Refilling the queue does not lower the flag by itself. Clearing the interrupt-enable bit masks the request and leaves the flag as it is. The serial shifter, the baud generator and the receive path are outside this block.

Top module: `txq_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 16'h0001 (flag set, overflow clear, level 0), the trigger select reads 0, and `tx_irq` is 0.
- R2: The control word (address 0) stores bit 7 transmit-interrupt enable, bit 6 receive-interrupt enable, bit 5 transmit enable, bit 4 receive enable, bit 3 receive-error-interrupt enable and bits 1:0 clock select. Bits 15:8 and bit 2 always read 0 and ignore writes, so writing 16'hFFFF reads back 16'h00FB.
- R3: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read. The address map is: 0 control, 1 status (bit 0 flag, bit 1 overflow, bits 12:8 queue level), 2 trigger select (bits 1:0: 0→8, 1→4, 2→2, 3→0 bytes). Address 3 reads 0.
- R4: A push stores `push_data` at the tail of a 16-byte queue. A push while the queue holds 16 bytes is dropped and sets the overflow bit. Writing status with bit 1 = 0 clears the overflow bit.
- R5: A `tx_load` strobe is accepted only when transmit enable is 1 and the queue is non-empty. An accepted strobe removes the oldest byte, which appears on `tx_byte` the next cycle. An ignored strobe changes neither the level nor `tx_byte`.
- R6: On an accepted transfer, the flag sets if the level before the transfer minus one is at or below the trigger count.
- R7: A status write with bit 0 = 0 clears the flag only when the flag was read as 1 since the last status write and the level is above the trigger count.
- R8: Any status write cancels a pending read-of-1. A status write of bit 0 = 0 that has no read-of-1 before it leaves the flag unchanged.
- R9: Pushing bytes that raise the level above the trigger count does not clear the flag.
- R10: `tx_irq` is 1 exactly when the flag and the transmit-interrupt enable are both 1. Clearing the enable drops `tx_irq` and keeps the flag.
- R11: When a transfer sets the flag in the same cycle as a valid clear write, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| push | input | 1 | Queue push strobe |
| push_data | input | 8 | Byte to enqueue |
| tx_load | input | 1 | Shift register takes a byte |
| tx_byte | output | 8 | Byte handed to the shift register |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_en | output | 1 | Transmit enable bit |
| rx_en | output | 1 | Receive enable bit |
| rx_irq_en | output | 1 | Receive interrupt enable bit |
| rxerr_irq_en | output | 1 | Receive-error interrupt enable bit |
| clk_sel | output | 2 | Clock select field |

## Verification
The hardest state to reach is a valid clear write that lands in the same cycle as a transfer that sets the flag. The flag must already be 1 and armed by a read. The level must be exactly one above the trigger count, so the write still qualifies while the transfer drops the level onto the threshold. The stimulus builds this state step by step. It drains the queue to the threshold, pushes bytes back, takes one byte to reach threshold plus one, reads status to arm, and then issues the write and the load strobe together. The other handshake corners are reached the same way: an unarmed write, a write after a disarming write, and an armed write at the threshold.

// File: rtl/txq_irq_pkg.sv
package txq_irq_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_TRIG = 2'd2;

  localparam logic [15:0] CTRL_WMASK = 16'h00FB;

  localparam int TIE_BIT  = 7;
  localparam int RIE_BIT  = 6;
  localparam int TE_BIT   = 5;
  localparam int RE_BIT   = 4;
  localparam int REIE_BIT = 3;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_OVF_BIT  = 1;
  localparam int STAT_LVL_LSB  = 8;

  // low-water mark in bytes for a trigger select code
  function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/txq_ctrl_reg.sv
module txq_ctrl_reg
  import txq_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl
);
  localparam logic [REG_W-1:0] MASK = REG_W'(CTRL_WMASK);

  always_ff @(posedge clk) begin
    if (rst)        ctrl <= '0;
    else if (wr_en) ctrl <= wdata & MASK;
  end
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              pop_allow,
  output logic [CW-1:0]     count,
  output logic              pop_ok,
  output logic              full_drop,
  output logic [DATA_W-1:0] tx_byte
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok;
  logic              is_full, is_empty;

  assign is_full   = (count == CW'(DEPTH));
  assign is_empty  = (count == '0);
  assign push_ok   = push && !is_full;
  assign full_drop = push && is_full;
  assign pop_ok    = pop_req && pop_allow && !is_empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      tx_byte <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok) begin
        rd_ptr  <= bump(rd_ptr);
        tx_byte <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && is_full && !pop_req) |=> (count == CW'(DEPTH)));

  // R5
  gated_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !pop_allow && !push) |=> ($stable(count) && $stable(tx_byte)));
endmodule

// File: rtl/txq_empty_flag.sv
module txq_empty_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop_ok,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  input  logic          rd_stat,
  input  logic          wr_stat,
  input  logic          wr_flag_bit,
  output logic          flag
);
  logic armed;
  logic set_ev, clr_ev;

  assign set_ev = pop_ok && ((count - CW'(1)) <= trig);
  assign clr_ev = wr_stat && !wr_flag_bit && armed && (count > trig);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (set_ev)      flag <= 1'b1;
      else if (clr_ev) flag <= 1'b0;
      if (wr_stat)               armed <= 1'b0;
      else if (rd_stat && flag)  armed <= 1'b1;
    end
  end

  // R6
  set_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && (count != '0) && ((count - CW'(1)) <= trig)) |=> flag);

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(wr_stat && !wr_flag_bit && (count > trig)));

  // R9
  push_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !wr_stat) |=> flag);
endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl
  import txq_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_irq,
  output logic              tx_en,
  output logic              rx_en,
  output logic              rx_irq_en,
  output logic              rxerr_irq_en,
  output logic [1:0]        clk_sel
);
  logic [REG_W-1:0] ctrl;
  logic [CW-1:0]    count, trig;
  logic [1:0]       trig_sel;
  logic             pop_ok, full_drop, flag, ovf;
  logic             wr_ctrl, wr_stat, wr_trig, rd_stat;
  logic [REG_W-1:0] stat_word;

  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_trig = bus_wr && (bus_addr == ADR_TRIG);
  assign rd_stat = bus_rd && (bus_addr == ADR_STAT);
  assign trig    = CW'(trig_bytes(trig_sel, DEPTH));

  txq_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wdata(bus_wdata), .ctrl(ctrl)
  );

  txq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop_req(tx_load), .pop_allow(ctrl[TE_BIT]), .count(count),
    .pop_ok(pop_ok), .full_drop(full_drop), .tx_byte(tx_byte)
  );

  txq_empty_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst(rst), .pop_ok(pop_ok), .count(count), .trig(trig),
    .rd_stat(rd_stat), .wr_stat(wr_stat),
    .wr_flag_bit(bus_wdata[STAT_FLAG_BIT]), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_sel <= '0;
      ovf      <= 1'b0;
    end else begin
      if (wr_trig) trig_sel <= bus_wdata[1:0];
      if (full_drop) ovf <= 1'b1;
      else if (wr_stat && !bus_wdata[STAT_OVF_BIT]) ovf <= 1'b0;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_FLAG_BIT] = flag;
    stat_word[STAT_OVF_BIT]  = ovf;
    stat_word[STAT_LVL_LSB +: CW] = count;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL: bus_rdata <= ctrl;
        ADR_STAT: bus_rdata <= stat_word;
        ADR_TRIG: bus_rdata <= REG_W'(trig_sel);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign tx_irq       = flag & ctrl[TIE_BIT];
  assign tx_en        = ctrl[TE_BIT];
  assign rx_en        = ctrl[RE_BIT];
  assign rx_irq_en    = ctrl[RIE_BIT];
  assign rxerr_irq_en = ctrl[REIE_BIT];
  assign clk_sel      = ctrl[1:0];

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[TIE_BIT]) |=> !tx_irq);
endmodule

// File: tb/test_txq_irq_ctrl.sv
`timescale 1ns/1ps
module test_txq_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_rd, bus_wr, push, tx_load;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  push_data, tx_byte;
  logic        tx_irq, tx_en, rx_en, rx_irq_en, rxerr_irq_en;
  logic [1:0]  clk_sel;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  txq_irq_ctrl i_txq_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .push(push), .push_data(push_data),
    .tx_load(tx_load), .tx_byte(tx_byte), .tx_irq(tx_irq), .tx_en(tx_en),
    .rx_en(rx_en), .rx_irq_en(rx_irq_en), .rxerr_irq_en(rxerr_irq_en), .clk_sel(clk_sel)
  );

  // reference model
  byte unsigned q[$];
  bit          mflag, marm, movf;
  logic [15:0] mctrl, mrd;
  logic [1:0]  mtrig;
  logic [7:0]  mtxb;

  function automatic int tv();
    case (mtrig)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete();
    mflag = 1; marm = 0; movf = 0;
    mctrl = 0; mrd = 0; mtrig = 0; mtxb = 0;
  endtask

  task automatic step(input logic [1:0] a, input logic r, input logic w, input logic [15:0] d,
                      input logic p, input logic [7:0] pd, input logic ld);
    int cnt, t;
    bit popok, pushok, setf, clrf;
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    push = p; push_data = pd; tx_load = ld;
    @(posedge clk);
    cnt = q.size(); t = tv();
    popok  = ld && mctrl[5] && cnt > 0;
    pushok = p && cnt < 16;
    setf   = popok && (cnt - 1) <= t;
    clrf   = w && a == 2'd1 && !d[0] && marm && cnt > t;
    if (r) begin
      case (a)
        2'd0: mrd = mctrl;
        2'd1: mrd = {3'b0, 5'(cnt), 6'b0, movf, mflag};
        2'd2: mrd = {14'b0, mtrig};
        default: mrd = 16'h0;
      endcase
    end
    if (w && a == 2'd1) marm = 0;
    else if (r && a == 2'd1 && mflag) marm = 1;
    if (setf) mflag = 1;
    else if (clrf) mflag = 0;
    if (p && cnt >= 16) movf = 1;
    else if (w && a == 2'd1 && !d[1]) movf = 0;
    if (w && a == 2'd0) mctrl = d & 16'h00FB;
    if (w && a == 2'd2) mtrig = d[1:0];
    if (popok) mtxb = q.pop_front();
    if (pushok) q.push_back(pd);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; push = 0; tx_load = 0;
    check(tx_irq === (mflag & mctrl[7]), "R10 irq", {15'b0, tx_irq}, {15'b0, mflag & mctrl[7]});
    check(tx_byte === mtxb, "R5 tx_byte", {8'b0, tx_byte}, {8'b0, mtxb});
    check(bus_rdata === mrd, "R3 rdata", bus_rdata, mrd);
    check({tx_en, rx_irq_en, rx_en, rxerr_irq_en, clk_sel} === {mctrl[5], mctrl[6], mctrl[4], mctrl[3], mctrl[1:0]},
          "R2 fields", {10'b0, tx_en, rx_irq_en, rx_en, rxerr_irq_en, clk_sel},
          {10'b0, mctrl[5], mctrl[6], mctrl[4], mctrl[3], mctrl[1:0]});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(a, 0, 1, d, 0, 8'h0, 0);
  endtask
  task automatic pu(input logic [7:0] b);
    step(2'd0, 0, 0, 16'h0, 1, b, 0);
  endtask
  task automatic ld();
    step(2'd0, 0, 0, 16'h0, 0, 8'h0, 1);
  endtask
  task automatic check_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    step(a, 1, 0, 16'h0, 0, 8'h0, 0);
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    push = 0; push_data = 0; tx_load = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    check(tx_irq === 1'b0, "R1 irq", {15'b0, tx_irq}, 16'h0);
    check_rd(2'd0, 16'h0000, "R1 ctrl");
    check_rd(2'd1, 16'h0001, "R1 status");

    // R2 field mask, R3 map
    wr(2'd0, 16'hFFFF);
    check_rd(2'd0, 16'h00FB, "R2 mask");
    wr(2'd0, 16'h0000);
    check_rd(2'd2, 16'h0000, "R3 trig");
    wr(2'd2, 16'h0003);
    check_rd(2'd2, 16'h0003, "R3 trig");
    check_rd(2'd3, 16'h0000, "R3 unmapped");
    wr(2'd2, 16'h0000);

    // R4 fill and overflow
    for (int i = 0; i < 16; i++) pu(8'h10 + 8'(i));
    check_rd(2'd1, 16'h1001, "R4 full");
    pu(8'hEE);
    check_rd(2'd1, 16'h1003, "R4 overflow");
    wr(2'd1, 16'h0001);
    check_rd(2'd1, 16'h1001, "R4 ovf clear");

    // R5 gated by transmit enable
    ld();
    check_rd(2'd1, 16'h1001, "R5 gated");
    wr(2'd0, 16'h0020);
    check_rd(2'd1, 16'h1001, "R7 arm");
    wr(2'd1, 16'h0002);
    check_rd(2'd1, 16'h1000, "R7 cleared");

    // R6 set at threshold
    ld();
    check(tx_byte === 8'h10, "R5 oldest", {8'b0, tx_byte}, 16'h0010);
    for (int i = 0; i < 6; i++) ld();
    check_rd(2'd1, 16'h0900, "R6 above");
    ld();
    check(tx_byte === 8'h17, "R5 order", {8'b0, tx_byte}, 16'h0017);
    check_rd(2'd1, 16'h0801, "R6 set");

    // R9, R8
    for (int i = 0; i < 4; i++) pu(8'h40 + 8'(i));
    check_rd(2'd1, 16'h0C01, "R9 push keeps flag");
    wr(2'd1, 16'h0003);
    wr(2'd1, 16'h0002);
    check_rd(2'd1, 16'h0C01, "R8 unarmed");
    wr(2'd1, 16'h0002);
    check_rd(2'd1, 16'h0C00, "R7 armed clear");

    // R10 interrupt
    wr(2'd0, 16'h00A0);
    check(tx_irq === 1'b0, "R10 flag low", {15'b0, tx_irq}, 16'h0);
    for (int i = 0; i < 4; i++) ld();
    check(tx_irq === 1'b1, "R10 raised", {15'b0, tx_irq}, 16'h1);
    wr(2'd0, 16'h0020);
    check(tx_irq === 1'b0, "R10 masked", {15'b0, tx_irq}, 16'h0);
    check_rd(2'd1, 16'h0801, "R10 flag kept");
    wr(2'd1, 16'h0002);
    check_rd(2'd1, 16'h0801, "R7 at threshold");

    // R11 set beats clear
    pu(8'h50); pu(8'h51);
    ld();
    check_rd(2'd1, 16'h0901, "R11 setup");
    step(2'd1, 0, 1, 16'h0002, 0, 8'h0, 1);
    check_rd(2'd1, 16'h0801, "R11 set wins");

    // drain with zero trigger
    wr(2'd2, 16'h0003);
    wr(2'd1, 16'h0002);
    check_rd(2'd1, 16'h0800, "R7 zero trig");
    for (int i = 0; i < 7; i++) ld();
    check_rd(2'd1, 16'h0100, "R6 not yet");
    ld();
    check_rd(2'd1, 16'h0001, "R6 empty");
    ld();
    check_rd(2'd1, 16'h0001, "R5 empty pop");
    step(2'd0, 0, 0, 16'h0, 1, 8'h77, 1);
    check_rd(2'd1, 16'h0101, "R5 push with empty pop");
    ld();
    check(tx_byte === 8'h77, "R5 last byte", {8'b0, tx_byte}, 16'h0077);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule